// File: doc/BRIEF.md
# Compressed Scan Wrapper with Chain Masking

This block wraps a small register-based core in a test structure. Every core flip-flop is a mux-input scan cell. The cells form several short chains that all shift in parallel, so a full pattern loads in as many cycles as one chain is long rather than the total cell count. A two-bit serial test input enters a fixed XOR spreading network that feeds every chain head. On the far side, the chain tails pass through a per-chain blocking stage and then a parity compactor that folds each slice into two registered test outputs.

A tester holds scan enable high for one chain length to load a pattern. It drops scan enable for one or more capture cycles, in which the cells take the core's next state. It then raises scan enable again, and the response shifts out while the next pattern shifts in. One core byte comes from an outside input and so stands for a value the tester cannot predict. A 4-bit mask code blocks that chain, or any other single chain, or all of them, so such a value cannot spoil the parity of its group.

Top module: `scan_cmp_wrap`

## Requirements
- R1: While `rst_n` is low, and after release until a new pattern has been shifted in, every scan cell holds 0 and `scan_out` is 0.
- R2: With `scan_en` high at a clock edge, each chain moves one place: cell j takes the old cell j-1, and cell 0 takes the chain's decompressed input. The tail of chain c is cell 7, which is bit 7 of core byte c.
- R3: The decompressed input of chain c is the XOR of the `scan_in` bits selected by the 2-bit mask (c mod 3)+1, where mask bit 0 selects `scan_in[0]` and mask bit 1 selects `scan_in[1]`.
- R4: With `scan_en` low at a clock edge, the cells capture the core's next state. For c below 7, byte c becomes byte c plus byte c+1, modulo 256. Byte 7 becomes byte 7 XOR `core_in`.
- R5: The response held after capture leaves through the chain tails during the same shift cycles that load the next pattern, with no separate unload phase.
- R6: At every clock edge, `scan_out[o]` is loaded with the XOR of the unmasked tails of chains 4o to 4o+3. The value for the slice present before an edge is therefore visible after that edge.
- R7: Mask code 0 blocks no chain. Code k, for k from 1 to 8, blocks chain k-1 only. Code 15 blocks all chains. A blocked chain contributes 0 to its parity, so with code 15 `scan_out` is 0 one cycle later.
- R8: Mask codes 9 to 14 block no chain and behave like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_en | input | 1 | High: shift. Low: capture the core's next state |
| scan_in | input | 2 | Serial test inputs feeding the decompressor |
| mask_code | input | 4 | Chain mask code, applied at the clock edge |
| core_in | input | 8 | Functional input of the core, used to form byte 7 |
| scan_out | output | 2 | Registered compacted parity outputs |

## Verification
The bench builds the block with its default parameters: 8 chains of 8 cells, 2 test inputs and 2 parity outputs. At this size each chain loads in eight shifts, so one stimulus run covers many load, capture and unload rounds, including back-to-back capture cycles. Every mask code is reachable, including the single-chain codes at both ends, code 15 and the unused codes. The chains fed from the same decompressor term, together with the byte that depends on `core_in`, show whether parity is folded over the right groups and whether blocking removes exactly one chain.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned MCODE_W = 4;
  localparam logic [MCODE_W-1:0] MCODE_NONE = '0;
  localparam logic [MCODE_W-1:0] MCODE_ALL  = '1;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic arst_ni,
  output logic srst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_no = sync_q[1];
endmodule

// File: rtl/scan_decomp.sv
module scan_decomp #(
  parameter int unsigned NIN = 2,
  parameter int unsigned NCH = 8
) (
  input  logic [NIN-1:0] si,
  output logic [NCH-1:0] chain_in
);
  localparam int unsigned NSUB = (1 << NIN) - 1;

  // Chain c taps a fixed nonempty subset of the test inputs, cycling through all subsets
  for (genvar c = 0; c < NCH; c++) begin : g_tap
    localparam int unsigned SELI = (c % NSUB) + 1;
    localparam logic [NIN-1:0] SEL = SELI[NIN-1:0];
    assign chain_in[c] = ^(si & SEL);
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           se,
  input  logic           sin,
  input  logic [LEN-1:0] func_d,
  output logic [LEN-1:0] cells,
  output logic           sout
);
  logic [LEN-1:0] cell_q;
  logic [LEN-1:0] cell_d;

  // Per-cell input mux: previous cell in shift, functional value in capture
  always_comb begin
    if (se) cell_d = {cell_q[LEN-2:0], sin};
    else    cell_d = func_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cell_q <= '0;
    else         cell_q <= cell_d;
  end

  assign cells = cell_q;
  assign sout  = cell_q[LEN-1];

  always @(posedge clk) begin
    if (!rst_ni) begin
      p_rst_clear_r1: assert (cell_q == '0)
        else $error("R1: scan cells not cleared during reset");
    end
  end

  p_shift_move_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    se |=> (cell_q[LEN-1:1] == $past(cell_q[LEN-2:0])) && (cell_q[0] == $past(sin)));

  p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !se |=> cell_q == $past(func_d));
endmodule

// File: rtl/scan_core.sv
module scan_core #(
  parameter int unsigned NCH = 8,
  parameter int unsigned LEN = 8
) (
  input  logic [NCH-1:0][LEN-1:0] st,
  input  logic [LEN-1:0]          ext_in,
  output logic [NCH-1:0][LEN-1:0] nxt
);
  for (genvar c = 0; c < NCH; c++) begin : g_word
    if (c < NCH - 1) begin : g_sum
      assign nxt[c] = st[c] + st[c+1];
    end else begin : g_ext
      assign nxt[c] = st[c] ^ ext_in;
    end
  end
endmodule

// File: rtl/scan_mask.sv
module scan_mask #(
  parameter int unsigned NCH = 8,
  parameter int unsigned MW  = scan_pkg::MCODE_W
) (
  input  logic [MW-1:0]  code,
  output logic [NCH-1:0] block
);
  always_comb begin
    block = '0;
    if (code == MW'(scan_pkg::MCODE_ALL)) begin
      block = '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (int'(code) == i + 1) block[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_compact.sv
module scan_compact #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NOUT = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  tails,
  input  logic [NCH-1:0]  block,
  output logic [NOUT-1:0] so
);
  localparam int unsigned GRP = NCH / NOUT;

  logic [NCH-1:0]  kept;
  logic [NOUT-1:0] par_d;

  assign kept = tails & ~block;

  for (genvar o = 0; o < NOUT; o++) begin : g_tree
    assign par_d[o] = ^kept[o*GRP +: GRP];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) so <= '0;
    else         so <= par_d;
  end

  p_all_blocked_zero_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (&block) |=> so == '0);
endmodule

// File: rtl/scan_cmp_wrap.sv
module scan_cmp_wrap #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned LEN  = 8,
  parameter int unsigned NIN  = 2,
  parameter int unsigned NOUT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scan_en,
  input  logic [NIN-1:0]                scan_in,
  input  logic [scan_pkg::MCODE_W-1:0]  mask_code,
  input  logic [LEN-1:0]                core_in,
  output logic [NOUT-1:0]               scan_out
);
  logic                    rst_ni;
  logic [NCH-1:0]          head;
  logic [NCH-1:0]          tail;
  logic [NCH-1:0]          block;
  logic [NCH-1:0][LEN-1:0] state;
  logic [NCH-1:0][LEN-1:0] next_state;

  scan_rst_sync u_rst (
    .clk     (clk),
    .arst_ni (rst_n),
    .srst_no (rst_ni)
  );

  scan_decomp #(.NIN(NIN), .NCH(NCH)) u_decomp (
    .si       (scan_in),
    .chain_in (head)
  );

  scan_core #(.NCH(NCH), .LEN(LEN)) u_core (
    .st     (state),
    .ext_in (core_in),
    .nxt    (next_state)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    scan_chain #(.LEN(LEN)) u_chain (
      .clk    (clk),
      .rst_ni (rst_ni),
      .se     (scan_en),
      .sin    (head[c]),
      .func_d (next_state[c]),
      .cells  (state[c]),
      .sout   (tail[c])
    );
  end

  scan_mask #(.NCH(NCH), .MW(scan_pkg::MCODE_W)) u_mask (
    .code  (mask_code),
    .block (block)
  );

  scan_compact #(.NCH(NCH), .NOUT(NOUT)) u_compact (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tails  (tail),
    .block  (block),
    .so     (scan_out)
  );
endmodule

// File: tb/tb_scan_cmp_wrap.sv
module tb_scan_cmp_wrap;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_en;
  logic [1:0] scan_in;
  logic [3:0] mask_code;
  logic [7:0] core_in;
  logic [1:0] scan_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] m [8];

  always #10 clk = ~clk;

  scan_cmp_wrap dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .mask_code(mask_code), .core_in(core_in), .scan_out(scan_out)
  );

  function automatic logic din(int c, logic [1:0] si);
    int sel = (c % 3) + 1;
    return ((sel & 1) != 0 ? si[0] : 1'b0) ^ ((sel & 2) != 0 ? si[1] : 1'b0);
  endfunction

  function automatic logic [7:0] blockf(logic [3:0] mc);
    if (mc == 4'd15) return 8'hFF;
    if (mc >= 4'd1 && mc <= 4'd8) return 8'd1 << (mc - 4'd1);
    return 8'h00;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: scan_out=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic se, logic [1:0] si, logic [3:0] mc, logic [7:0] ci, string tag);
    logic [7:0] blk = blockf(mc);
    logic [1:0] e = '0;
    logic [7:0] t [8];
    for (int c = 0; c < 8; c++) e[c/4] ^= m[c][7] & ~blk[c];
    for (int c = 0; c < 8; c++) t[c] = m[c];
    for (int c = 0; c < 8; c++) begin
      if (se) m[c] = {t[c][6:0], din(c, si)};
      else if (c < 7) m[c] = t[c] + t[c+1];
      else m[c] = t[7] ^ ci;
    end
    scan_en = se; scan_in = si; mask_code = mc; core_in = ci;
    @(posedge clk); #5;
    check(tag, scan_out, e);
  endtask

  function automatic string tagf(logic se, logic [3:0] mc);
    if (!se) return "R4 R6";
    if (mc == 4'd0) return "R2 R3 R5 R6";
    if (mc <= 4'd8 || mc == 4'd15) return "R7";
    return "R8";
  endfunction

  function automatic logic [3:0] pick_mask();
    int r = $urandom_range(0, 9);
    if (r < 4) return 4'd0;
    if (r < 7) return 4'($urandom_range(1, 8));
    if (r < 8) return 4'd15;
    return 4'($urandom_range(9, 14));
  endfunction

  task automatic load_unload(logic [3:0] mc_fixed, bit use_fixed);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] si = 2'($urandom_range(0, 3));
      logic [3:0] mc = use_fixed ? mc_fixed : pick_mask();
      step(1'b1, si, mc, 8'h00, tagf(1'b1, mc));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) m[c] = 8'h00;
    rst_n = 1'b0; scan_en = 1'b1; scan_in = '0; mask_code = '0; core_in = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset", scan_out, 2'b00);
    rst_n = 1'b1;
    // R1: flush after release shows all-zero cells
    for (int k = 0; k < 8; k++) step(1'b1, 2'b00, 4'd0, 8'h00, "R1");
    // R3: load with each input alone, capture, unload unmasked
    for (int k = 0; k < 8; k++) step(1'b1, 2'b01, 4'd0, 8'h00, "R3");
    step(1'b0, 2'b00, 4'd0, 8'hA5, "R4");
    for (int k = 0; k < 8; k++) step(1'b1, 2'b10, 4'd0, 8'h00, "R5");
    // R7: all masked during capture and unload
    step(1'b0, 2'b00, 4'd15, 8'h3C, "R7");
    for (int k = 0; k < 8; k++) step(1'b1, 2'b11, 4'd15, 8'h00, "R7");
    // R7: block chain 7 (unpredictable byte) and chain 0
    step(1'b0, 2'b00, 4'd8, 8'hFF, "R7");
    load_unload(4'd8, 1);
    step(1'b0, 2'b00, 4'd1, 8'h0F, "R7");
    load_unload(4'd1, 1);
    // R8: unused codes
    step(1'b0, 2'b00, 4'd9, 8'h81, "R8");
    load_unload(4'd14, 1);
    step(1'b0, 2'b00, 4'd0, 8'h18, "R4");
    step(1'b0, 2'b00, 4'd0, 8'h42, "R4");
    load_unload(4'd11, 1);
    // random rounds
    for (int r = 0; r < 60; r++) begin
      int ncap = $urandom_range(1, 2);
      load_unload(4'd0, 0);
      for (int k = 0; k < ncap; k++) begin
        logic [3:0] mc = pick_mask();
        step(1'b0, 2'($urandom_range(0, 3)), mc, 8'($urandom_range(0, 255)), tagf(1'b0, mc));
      end
    end
    load_unload(4'd0, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule